// File: doc/BRIEF.md
# Byte/Word Accumulator ALU

This block is the arithmetic and logic engine of a small CPU with two 8-bit accumulators that can be paired as one 16-bit word. Each clock it takes an operation code, two operands and the current condition flags. One clock later it presents the result, a write-enable that tells the register file whether the result is to be stored, and the new flags. Operand fetch, register write-back and instruction sequencing belong to the surrounding core.

Byte operations take their operands from the low bytes of `x_i` and `y_i` and return the result in `res_o[7:0]` with `res_o[15:8]` zero. Word operations use all 16 bits. Multiply takes the two low bytes as the two accumulators and returns a 16-bit product. Sign extension widens the low byte of `x_i` into a full word. Decimal adjust corrects the low byte of `x_i` after a packed-BCD addition.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `res_o`, `wr_o` and `flags_o` are all zero. Otherwise each output reflects the inputs sampled at the previous rising clock edge. The flags bus is ordered {H,N,Z,V,C}, with H in bit 4 and C in bit 0. Unless a rule below says otherwise, N is bit 7 of a byte result and bit 15 of a word result, Z means that result is zero, `wr_o` is 1, and H keeps its input value.
- R2: Codes 0 and 1 add the two bytes, with code 1 also adding the input C. C is the carry out of bit 7, V is signed overflow, and H is the carry out of bit 3.
- R3: Codes 2 and 3 subtract the second byte from the first, with code 3 also subtracting the input C. Code 4 computes the same difference as code 2 but drives `wr_o` to 0. In all three, C is the borrow and V is signed overflow.
- R4: Codes 5, 6 and 7 give the bitwise AND, OR and XOR of the two bytes. V is cleared and C keeps its input value.
- R5: Code 8 returns the one's complement of the first byte, with V=0 and C=1. Code 9 returns its two's-complement negation, with V=1 only for 0x80 and C=1 for any nonzero operand.
- R6: Code 10 returns zero with N=0, Z=1, V=0 and C=0.
- R7: Code 11 increments the first byte, with V=1 only for 0x7F. Code 12 decrements it, with V=1 only for 0x80. Both keep C.
- R8: The shift and rotate codes each move one bit. Code 13 shifts left and brings in a 0. Code 14 shifts right and keeps bit 7. Code 15 shifts right and brings in a 0. Code 16 rotates left through C. Code 17 rotates right through C. C receives the bit shifted out, and V = N XOR C.
- R9: Code 18 tests the first byte: `res_o` shows that byte, `wr_o` is 0, V is cleared and C is kept.
- R10: Code 19 returns the unsigned product of the two bytes as a word. Z means the product is zero, C is product bit 7, and N, V and H are kept.
- R11: Code 20 returns a word whose high byte is eight copies of bit 7 of the first byte and whose low byte is that byte. N and Z follow the word, and V and C are kept.
- R12: Code 21 adds a correction to the first byte. The correction includes 0x06 when H is set or the low nibble exceeds 9. It includes 0x60 when C is set, or the high nibble exceeds 9, or the high nibble is at least 9 while the low nibble exceeds 9. C out is 1 exactly when 0x60 was applied, and V is kept.
- R13: Codes 22 and 23 add and subtract the full 16-bit operands with no carry input. Code 24 computes the same difference as code 23 with `wr_o`=0. In all three, C is the carry or borrow out of bit 15 and V is signed overflow.
- R14: Codes 25 to 31 give `res_o`=0 and `wr_o`=0, and pass every flag through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| x_i | input | 16 | First operand (low byte for byte operations) |
| y_i | input | 16 | Second operand (low byte for byte operations) |
| flags_i | input | 5 | Incoming flags {H,N,Z,V,C} |
| res_o | output | 16 | Result |
| wr_o | output | 1 | Result is to be written back |
| flags_o | output | 5 | Updated flags {H,N,Z,V,C} |

## Verification
Every result, write-enable and flag is due exactly one rising edge after its operation code and operands are applied. No operation takes longer, and none is ready sooner. The bench applies each stimulus on a falling edge, lets one rising edge register it, and compares all three outputs on the next falling edge, so each vector occupies one cycle. Reset is checked by the same rule: outputs are compared one falling edge after reset is asserted.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OP_W   = 5;
    localparam int FLAG_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_EOR  = 5'd7,
        OP_COM  = 5'd8,
        OP_NEG  = 5'd9,
        OP_CLR  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_ASL  = 5'd13,
        OP_ASR  = 5'd14,
        OP_LSR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ROR  = 5'd17,
        OP_TST  = 5'd18,
        OP_MUL  = 5'd19,
        OP_SEX  = 5'd20,
        OP_DAA  = 5'd21,
        OP_ADDW = 5'd22,
        OP_SUBW = 5'd23,
        OP_CMPW = 5'd24
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_ASL,
        SH_ASR,
        SH_LSR,
        SH_ROL,
        SH_ROR
    } shift_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic              wr;
        flags_t            fl;
    } alu_out_t;

endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   full;

    // Subtraction is a + ~b + ~borrow; the carry out is inverted into a borrow.
    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        c_eff  = sub_i ^ cin_i;
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum_o  = full[W-1:0];
        cout_o = full[W] ^ sub_i;
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end

endmodule

// File: rtl/acc_shift8.sv
module acc_shift8
    import acc_alu_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  shift_e       kind_i,
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    always_comb begin
        res_o  = val_i;
        cout_o = 1'b0;
        case (kind_i)
            SH_ASL: begin
                res_o  = {val_i[W-2:0], 1'b0};
                cout_o = val_i[W-1];
            end
            SH_ASR: begin
                res_o  = {val_i[W-1], val_i[W-1:1]};
                cout_o = val_i[0];
            end
            SH_LSR: begin
                res_o  = {1'b0, val_i[W-1:1]};
                cout_o = val_i[0];
            end
            SH_ROL: begin
                res_o  = {val_i[W-2:0], cin_i};
                cout_o = val_i[W-1];
            end
            SH_ROR: begin
                res_o  = {cin_i, val_i[W-1:1]};
                cout_o = val_i[0];
            end
            default: begin
                res_o  = val_i;
                cout_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_bcd_adjust.sv
module acc_bcd_adjust (
    input  logic [7:0] val_i,
    input  logic       h_i,
    input  logic       c_i,
    output logic [7:0] res_o,
    output logic       c_o
);

    logic [3:0] lo_nib;
    logic [3:0] hi_nib;
    logic       fix_lo;
    logic       fix_hi;

    always_comb begin
        lo_nib = val_i[3:0];
        hi_nib = val_i[7:4];
        fix_lo = h_i || (lo_nib > 4'd9);
        // A high nibble of 9 overflows once the low correction carries into it.
        fix_hi = c_i || (hi_nib > 4'd9) || ((hi_nib >= 4'd9) && (lo_nib > 4'd9));
        res_o  = val_i + {1'b0, fix_hi, fix_hi, 1'b0, 1'b0, fix_lo, fix_lo, 1'b0};
        c_o    = fix_hi;
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [WORD_W-1:0] x_i,
    input  logic [WORD_W-1:0] y_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [WORD_W-1:0] res_o,
    output logic              wr_o,
    output logic [FLAG_W-1:0] flags_o
);

    alu_op_e           op;
    flags_t            fin;
    logic [BYTE_W-1:0] xb;
    logic [BYTE_W-1:0] yb;

    assign op  = alu_op_e'(op_i);
    assign fin = flags_t'(flags_i);
    assign xb  = x_i[BYTE_W-1:0];
    assign yb  = y_i[BYTE_W-1:0];

    // Byte adder/subtractor
    logic              sub8;
    logic              cin8;
    logic [BYTE_W-1:0] sum8;
    logic              co8;
    logic              ov8;

    assign sub8 = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    assign cin8 = ((op == OP_ADC) || (op == OP_SBC)) && fin.c;

    acc_addsub #(.W(BYTE_W)) i_add8 (
        .a_i    (xb),
        .b_i    (yb),
        .cin_i  (cin8),
        .sub_i  (sub8),
        .sum_o  (sum8),
        .cout_o (co8),
        .ovf_o  (ov8)
    );

    // Word adder/subtractor, no carry input
    logic              sub16;
    logic [WORD_W-1:0] sum16;
    logic              co16;
    logic              ov16;

    assign sub16 = (op == OP_SUBW) || (op == OP_CMPW);

    acc_addsub #(.W(WORD_W)) i_add16 (
        .a_i    (x_i),
        .b_i    (y_i),
        .cin_i  (1'b0),
        .sub_i  (sub16),
        .sum_o  (sum16),
        .cout_o (co16),
        .ovf_o  (ov16)
    );

    // Shifter
    shift_e            sh_kind;
    logic [BYTE_W-1:0] sh_res;
    logic              sh_c;

    always_comb begin
        case (op)
            OP_ASR:  sh_kind = SH_ASR;
            OP_LSR:  sh_kind = SH_LSR;
            OP_ROL:  sh_kind = SH_ROL;
            OP_ROR:  sh_kind = SH_ROR;
            default: sh_kind = SH_ASL;
        endcase
    end

    acc_shift8 #(.W(BYTE_W)) i_shift (
        .kind_i (sh_kind),
        .val_i  (xb),
        .cin_i  (fin.c),
        .res_o  (sh_res),
        .cout_o (sh_c)
    );

    // Decimal adjust
    logic [BYTE_W-1:0] bcd_res;
    logic              bcd_c;

    acc_bcd_adjust i_bcd (
        .val_i (xb),
        .h_i   (fin.h),
        .c_i   (fin.c),
        .res_o (bcd_res),
        .c_o   (bcd_c)
    );

    // Multiply and sign extension
    logic [WORD_W-1:0] prod;
    logic [WORD_W-1:0] sext;

    assign prod = WORD_W'(xb) * WORD_W'(yb);
    assign sext = {{(WORD_W-BYTE_W){xb[BYTE_W-1]}}, xb};

    // Next-state computation
    alu_out_t          out_d;
    alu_out_t          out_q;
    logic [BYTE_W-1:0] r8;
    logic [WORD_W-1:0] r16;
    logic              byte_nz;
    logic              word_nz;

    always_comb begin
        out_d    = '0;
        out_d.fl = fin;
        out_d.wr = 1'b1;
        r8       = '0;
        r16      = '0;
        byte_nz  = 1'b1;
        word_nz  = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                r8         = sum8;
                out_d.fl.h = xb[4] ^ yb[4] ^ sum8[4];
                out_d.fl.v = ov8;
                out_d.fl.c = co8;
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                r8         = sum8;
                out_d.fl.v = ov8;
                out_d.fl.c = co8;
                out_d.wr   = (op != OP_CMP);
            end
            OP_AND: begin
                r8         = xb & yb;
                out_d.fl.v = 1'b0;
            end
            OP_OR: begin
                r8         = xb | yb;
                out_d.fl.v = 1'b0;
            end
            OP_EOR: begin
                r8         = xb ^ yb;
                out_d.fl.v = 1'b0;
            end
            OP_COM: begin
                r8         = ~xb;
                out_d.fl.v = 1'b0;
                out_d.fl.c = 1'b1;
            end
            OP_NEG: begin
                r8         = BYTE_W'(0) - xb;
                out_d.fl.v = (xb == {1'b1, {(BYTE_W-1){1'b0}}});
                out_d.fl.c = (xb != '0);
            end
            OP_CLR: begin
                r8         = '0;
                out_d.fl.v = 1'b0;
                out_d.fl.c = 1'b0;
            end
            OP_INC: begin
                r8         = xb + BYTE_W'(1);
                out_d.fl.v = (xb == {1'b0, {(BYTE_W-1){1'b1}}});
            end
            OP_DEC: begin
                r8         = xb - BYTE_W'(1);
                out_d.fl.v = (xb == {1'b1, {(BYTE_W-1){1'b0}}});
            end
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
                r8         = sh_res;
                out_d.fl.c = sh_c;
                out_d.fl.v = sh_res[BYTE_W-1] ^ sh_c;
            end
            OP_TST: begin
                r8         = xb;
                out_d.fl.v = 1'b0;
                out_d.wr   = 1'b0;
            end
            OP_MUL: begin
                r16        = prod;
                byte_nz    = 1'b0;
                out_d.fl.z = (prod == '0);
                out_d.fl.c = prod[BYTE_W-1];
            end
            OP_SEX: begin
                r16     = sext;
                byte_nz = 1'b0;
                word_nz = 1'b1;
            end
            OP_DAA: begin
                r8         = bcd_res;
                out_d.fl.c = bcd_c;
            end
            OP_ADDW, OP_SUBW, OP_CMPW: begin
                r16        = sum16;
                byte_nz    = 1'b0;
                word_nz    = 1'b1;
                out_d.fl.v = ov16;
                out_d.fl.c = co16;
                out_d.wr   = (op != OP_CMPW);
            end
            default: begin
                byte_nz  = 1'b0;
                out_d.wr = 1'b0;
            end
        endcase

        if (byte_nz) begin
            out_d.res  = {{(WORD_W-BYTE_W){1'b0}}, r8};
            out_d.fl.n = r8[BYTE_W-1];
            out_d.fl.z = (r8 == '0);
        end else begin
            out_d.res = r16;
            if (word_nz) begin
                out_d.fl.n = r16[WORD_W-1];
                out_d.fl.z = (r16 == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o   = out_q.res;
    assign wr_o    = out_q.wr;
    assign flags_o = out_q.fl;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  op_i,
    input logic [15:0] x_i,
    input logic [15:0] y_i,
    input logic [4:0]  flags_i,
    input logic [15:0] res_o,
    input logic        wr_o,
    input logic [4:0]  flags_o
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (res_o == 16'h0) && !wr_o && (flags_o == 5'h0));

    assert_compare_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd4) |=> !wr_o);

    assert_logic_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 5'd5 && op_i <= 5'd7) |=> (flags_o[0] == $past(flags_i[0])) && !flags_o[1]);

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd10) |=> (res_o == 16'h0) && wr_o && (flags_o[3:0] == 4'b0100));

    assert_test_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd18) |=> !wr_o && (res_o == {8'h0, $past(x_i[7:0])}));

    assert_mul_product_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd19) |=> res_o == (16'($past(x_i[7:0])) * 16'($past(y_i[7:0]))));

    assert_word_compare_no_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd24) |=> !wr_o);

    assert_unknown_op_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 5'd24) |=> !wr_o && (res_o == 16'h0) && (flags_o == $past(flags_i)));

endmodule

bind acc_alu acc_alu_chk i_acc_alu_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .x_i     (x_i),
    .y_i     (y_i),
    .flags_i (flags_i),
    .res_o   (res_o),
    .wr_o    (wr_o),
    .flags_o (flags_o)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [15:0] x_i = '0;
    logic [15:0] y_i = '0;
    logic [4:0]  flags_i = '0;
    logic [15:0] res_o;
    logic        wr_o;
    logic [4:0]  flags_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    acc_alu i_acc_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .x_i     (x_i),
        .y_i     (y_i),
        .flags_i (flags_i),
        .res_o   (res_o),
        .wr_o    (wr_o),
        .flags_o (flags_o)
    );

    function automatic string req_of(int op);
        case (op)
            0, 1:              return "R2";
            2, 3, 4:           return "R3";
            5, 6, 7:           return "R4";
            8, 9:              return "R5";
            10:                return "R6";
            11, 12:            return "R7";
            13, 14, 15, 16, 17: return "R8";
            18:                return "R9";
            19:                return "R10";
            20:                return "R11";
            21:                return "R12";
            22, 23, 24:        return "R13";
            default:           return "R14";
        endcase
    endfunction

    // Expected {wr, H, N, Z, V, C, result}
    function automatic logic [21:0] model(int op, int x, int y, int fl);
        int a  = x & 255;
        int b  = y & 255;
        int sa = (a >= 128) ? a - 256 : a;
        int sb = (b >= 128) ? b - 256 : b;
        int h  = (fl >> 4) & 1;
        int n  = (fl >> 3) & 1;
        int z  = (fl >> 2) & 1;
        int v  = (fl >> 1) & 1;
        int c  = fl & 1;
        int r  = 0;
        int wr = 1;
        int nz = 1;
        int cin, s, sv, wx, wy, swx, swy, lo, hi, cf;
        case (op)
            0, 1: begin
                cin = (op == 1) ? c : 0;
                s = a + b + cin;
                sv = sa + sb + cin;
                r = s & 255;
                h = (((a & 15) + (b & 15) + cin) > 15) ? 1 : 0;
                c = (s > 255) ? 1 : 0;
                v = (sv > 127 || sv < -128) ? 1 : 0;
            end
            2, 3, 4: begin
                cin = (op == 3) ? c : 0;
                s = a - b - cin;
                sv = sa - sb - cin;
                r = s & 255;
                c = (s < 0) ? 1 : 0;
                v = (sv > 127 || sv < -128) ? 1 : 0;
                wr = (op == 4) ? 0 : 1;
            end
            5: begin r = a & b; v = 0; end
            6: begin r = a | b; v = 0; end
            7: begin r = a ^ b; v = 0; end
            8: begin r = 255 - a; v = 0; c = 1; end
            9: begin r = (256 - a) & 255; v = (a == 128) ? 1 : 0; c = (a != 0) ? 1 : 0; end
            10: begin r = 0; v = 0; c = 0; end
            11: begin r = (a + 1) & 255; v = (a == 127) ? 1 : 0; end
            12: begin r = (a + 255) & 255; v = (a == 128) ? 1 : 0; end
            13, 14, 15, 16, 17: begin
                case (op)
                    13: begin r = (a * 2) & 255; c = a >> 7; end
                    14: begin r = (a >> 1) | (a & 128); c = a & 1; end
                    15: begin r = a >> 1; c = a & 1; end
                    16: begin r = ((a * 2) & 255) | c; c = a >> 7; end
                    default: begin r = (a >> 1) | (c * 128); c = a & 1; end
                endcase
                v = ((r >> 7) & 1) ^ c;
            end
            18: begin r = a; v = 0; wr = 0; end
            19: begin
                r = a * b;
                nz = 0;
                z = (r == 0) ? 1 : 0;
                c = (r >> 7) & 1;
            end
            20: begin r = (a >= 128) ? 65280 + a : a; nz = 2; end
            21: begin
                lo = a & 15;
                hi = a >> 4;
                cf = 0;
                if (h == 1 || lo > 9) cf = cf + 6;
                if (c == 1 || hi > 9 || (hi > 8 && lo > 9)) begin
                    cf = cf + 96;
                    c = 1;
                end
                r = (a + cf) & 255;
            end
            22, 23, 24: begin
                wx = x & 65535;
                wy = y & 65535;
                swx = (wx >= 32768) ? wx - 65536 : wx;
                swy = (wy >= 32768) ? wy - 65536 : wy;
                if (op == 22) begin
                    s = wx + wy;
                    sv = swx + swy;
                    c = (s > 65535) ? 1 : 0;
                end else begin
                    s = wx - wy;
                    sv = swx - swy;
                    c = (s < 0) ? 1 : 0;
                end
                r = s & 65535;
                v = (sv > 32767 || sv < -32768) ? 1 : 0;
                wr = (op == 24) ? 0 : 1;
                nz = 2;
            end
            default: begin r = 0; wr = 0; nz = 0; end
        endcase
        if (nz == 1) begin
            n = (r >> 7) & 1;
            z = ((r & 255) == 0) ? 1 : 0;
        end else if (nz == 2) begin
            n = (r >> 15) & 1;
            z = (r == 0) ? 1 : 0;
        end
        return {wr[0], h[0], n[0], z[0], v[0], c[0], r[15:0]};
    endfunction

    task automatic check(string req, logic [21:0] exp);
        logic [21:0] act;
        act = {wr_o, flags_o, res_o};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s op=%0d x=%h y=%h fl=%b: actual wr=%b fl=%b res=%h expected wr=%b fl=%b res=%h",
                     req, op_i, x_i, y_i, flags_i, act[21], act[20:16], act[15:0],
                     exp[21], exp[20:16], exp[15:0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] yv [8];
        yv[0] = 8'h00; yv[1] = 8'h01; yv[2] = 8'h0F; yv[3] = 8'h7F;
        yv[4] = 8'h80; yv[5] = 8'hFF; yv[6] = 8'h55; yv[7] = 8'h9A;

        // R1: outputs held at zero during reset
        repeat (3) @(negedge clk);
        check("R1", 22'h0);
        rst_n = 1'b1;

        for (int op = 0; op < 32; op++) begin
            for (int k = 0; k < 8; k++) begin
                for (int xb = 0; xb < 256; xb++) begin
                    op_i    = 5'(op);
                    x_i     = {8'(xb + k * 37 + op), 8'(xb)};
                    y_i     = {8'(yv[k] ^ 8'h3C ^ 8'(xb)), yv[k]};
                    flags_i = 5'(xb ^ (k * 5) ^ op);
                    @(negedge clk);
                    // R1: result due one clock after the operands
                    check(req_of(op), model(op, int'(x_i), int'(y_i), int'(flags_i)));
                end
            end
        end

        // R1: asynchronous reset in mid-run zeroes the outputs
        op_i    = 5'd0;
        x_i     = 16'h00FF;
        y_i     = 16'h0001;
        flags_i = 5'h1F;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 22'h0);

        finish_run();
    end

endmodule